// File: doc/BRIEF.md
# SPI Flash Page-Write Sequencer

This block is the host side of a serial-flash page write. A single start request, with a 24-bit target address and a byte count, runs the whole handshake on a four-wire SPI bus. First a one-byte write-enable frame goes out. Next comes the program frame: the opcode, the address sent MSB first, and the payload bytes. The payload is pulled one byte at a time from a ready/valid stream. The block then reads the flash status register in repeated two-byte frames until the busy flag drops. The request finishes with a one-cycle `done` pulse, or with an `err` pulse and a reason code.

The bus runs in SPI mode 0. SCK idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge. Each SCK half period lasts `DIV` clock cycles. Chip select is released only when the last bit of a whole byte has been clocked, so the flash always sees a complete program frame. The block checks each request before anything reaches the bus. A count of zero is refused. So is any request whose count runs past the end of the 256-byte page that holds the start address, because the flash would otherwise wrap and overwrite bytes earlier in that page.

Top module: `pgwr_seq`

## Requirements
- R1: A start with `len` of 0, or with `addr[7:0] + len` greater than 256, produces an `err` pulse with `err_code` = 1 within two cycles. `cs_n` stays high and no SCK edge is produced.
- R2: The first frame of an accepted request holds exactly one byte, 0x06.
- R3: The second frame is 0x02, then `addr[23:16]`, `addr[15:8]` and `addr[7:0]`, then exactly `len` payload bytes in the order they were accepted. Every byte is sent MSB first.
- R4: SCK is low whenever `cs_n` is high. MOSI never changes while SCK is high or in the cycle SCK rises.
- R5: `cs_n` rises only while SCK is low, and only after a whole number of bytes (a multiple of 8 rising SCK edges) in the frame.
- R6: After the program frame, the block sends status frames of two bytes: 0x05, then a filler byte. The second byte is read from MISO. Bit 0 is the busy flag and bit 1 is the write-enable flag. A new status frame follows while bit 0 reads 1.
- R7: When a status byte reads bit 0 = 0, the block ends the request. It gives a `done` pulse if bit 1 is 0, or an `err` pulse with `err_code` = 3 if bit 1 is 1. `done` and `err` are single-cycle and never high together.
- R8: If `POLL_MAX` status frames in a row all read busy, the request ends with an `err` pulse and `err_code` = 2, with no further frames.
- R9: `wr_ready` is high only during the payload part of the program frame. Each cycle with `wr_valid` and `wr_ready` both high moves exactly one byte.
- R10: Every SCK high phase lasts exactly `DIV` clock cycles.
- R11: After reset, `cs_n` = 1, `sck` = 0, and `done`, `err` and `wr_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken while idle |
| addr | input | ADDR_W | Flash byte address of the first payload byte |
| len | input | LEN_W | Payload byte count, 1 to 256 |
| wr_data | input | 8 | Payload byte |
| wr_valid | input | 1 | Payload byte available |
| wr_ready | output | 1 | Block takes the payload byte this cycle |
| done | output | 1 | Successful completion pulse |
| err | output | 1 | Failure pulse |
| err_code | output | 2 | Failure reason: 1 bad request, 2 poll timeout, 3 write-enable still set |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash |

## Verification
A wrong frame, byte or bit counter shows at the pins within one frame. It appears as an extra or missing byte, a wrong address byte, or a `cs_n` rise that does not fall on a byte boundary. The bench's flash model records each of these as soon as chip select rises. A corrupted status capture or poll counter shows as the wrong end code, or as a status-frame count that differs from the number of busy replies. This is visible by the end of the request. A divider fault changes the measured SCK high time on the first bit of the first frame.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_BYTE, ST_DWAIT} st_t;
  typedef enum logic [1:0] {FR_WREN, FR_PROG, FR_STAT} fr_t;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_REQ  = 2'd1;
  localparam logic [1:0] ERR_TMO  = 2'd2;
  localparam logic [1:0] ERR_WEL  = 2'd3;

  // status register bit positions (last two bits shifted in)
  localparam int BUSY_BIT = 0;
  localparam int WEL_BIT  = 1;
endpackage

// File: rtl/pgwr_reqchk.sv
module pgwr_reqchk #(
  parameter int PAGE_BYTES = 256,
  parameter int LEN_W      = $clog2(PAGE_BYTES) + 1
) (
  input  logic [$clog2(PAGE_BYTES)-1:0] off,
  input  logic [LEN_W-1:0]              len,
  output logic                          ok
);
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(off) + SUM_W'(len);
    ok  = (len != '0) && (sum <= SUM_W'(PAGE_BYTES));
  end
endmodule

// File: rtl/pgwr_shifter.sv
module pgwr_shifter #(
  parameter int DIV  = 2,
  parameter int RX_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [7:0]      tx,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic [RX_W-1:0] rx,
  output logic            fin
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          active;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sr;

  assign mosi = sr[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sr     <= '0;
      sck    <= 1'b0;
      rx     <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          sr     <= tx;
          cnt    <= '0;
          bitn   <= '0;
        end
      end else if (cnt == CW'(DIV - 1)) begin
        cnt <= '0;
        if (!sck) begin
          sck <= 1'b1;
          if (RX_W > 1) rx <= {rx[RX_W-2:0], miso};
          else          rx <= RX_W'(miso);
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sr   <= {sr[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int DIV        = 2,
  parameter int POLL_MAX   = 1000,
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  parameter int LEN_W      = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int HDR        = 1 + ADDR_BYTES;
  localparam int IDX_W      = LEN_W + 1;
  localparam int GAP_CYC    = 2 * DIV;
  localparam int GW         = $clog2(GAP_CYC + 1);
  localparam int PW         = $clog2(POLL_MAX + 1);

  st_t               st;
  fr_t               fr;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx, idx_nx, flen;
  logic [GW-1:0]     gcnt;
  logic [PW-1:0]     polls;
  logic              go, fin, req_ok;
  logic [7:0]        txb, hdr_nx, op_fr;
  logic [1:0]        stat;

  pgwr_reqchk #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_req (
    .off(addr[OFF_W-1:0]), .len(len), .ok(req_ok)
  );

  pgwr_shifter #(.DIV(DIV), .RX_W(2)) u_shf (
    .clk(clk), .rst(rst), .go(go), .tx(txb), .miso(miso),
    .sck(sck), .mosi(mosi), .rx(stat), .fin(fin)
  );

  assign wr_ready = (st == ST_DWAIT);
  assign idx_nx   = idx + IDX_W'(1);

  always_comb begin
    case (fr)
      FR_WREN: begin flen = IDX_W'(1); op_fr = OP_WREN; end
      FR_PROG: begin flen = IDX_W'(HDR) + IDX_W'(len_q); op_fr = OP_PROG; end
      default: begin flen = IDX_W'(2); op_fr = OP_RDSR; end
    endcase
  end

  always_comb begin
    hdr_nx = 8'h00;
    if (fr == FR_PROG) begin
      for (int i = 1; i <= ADDR_BYTES; i++) begin
        if (idx_nx == IDX_W'(i)) hdr_nx = addr_q[8*(ADDR_BYTES-i) +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      fr       <= FR_WREN;
      addr_q   <= '0;
      len_q    <= '0;
      idx      <= '0;
      gcnt     <= '0;
      polls    <= '0;
      go       <= 1'b0;
      txb      <= '0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (!req_ok) begin
              err      <= 1'b1;
              err_code <= ERR_REQ;
            end else begin
              addr_q   <= addr;
              len_q    <= len;
              fr       <= FR_WREN;
              gcnt     <= '0;
              err_code <= ERR_NONE;
              st       <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) begin
            gcnt <= '0;
            cs_n <= 1'b0;
            idx  <= '0;
            go   <= 1'b1;
            txb  <= op_fr;
            st   <= ST_BYTE;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
        ST_BYTE: begin
          if (fin) begin
            if (idx_nx == flen) begin
              cs_n <= 1'b1;
              gcnt <= '0;
              st   <= ST_GAP;
              case (fr)
                FR_WREN: fr <= FR_PROG;
                FR_PROG: begin fr <= FR_STAT; polls <= '0; end
                default: begin
                  if (stat[BUSY_BIT]) begin
                    if (polls == PW'(POLL_MAX - 1)) begin
                      err      <= 1'b1;
                      err_code <= ERR_TMO;
                      st       <= ST_IDLE;
                    end else begin
                      polls <= polls + PW'(1);
                    end
                  end else begin
                    st <= ST_IDLE;
                    if (stat[WEL_BIT]) begin
                      err      <= 1'b1;
                      err_code <= ERR_WEL;
                    end else begin
                      done <= 1'b1;
                    end
                  end
                end
              endcase
            end else begin
              idx <= idx_nx;
              if (fr == FR_PROG && idx_nx >= IDX_W'(HDR)) begin
                st <= ST_DWAIT;
              end else begin
                go  <= 1'b1;
                txb <= hdr_nx;
              end
            end
          end
        end
        default: begin
          if (wr_valid) begin
            go  <= 1'b1;
            txb <= wr_data;
            st  <= ST_BYTE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic sck,
  input logic cs_n,
  input logic mosi,
  input logic wr_ready,
  input logic done,
  input logic err
);
  logic       sck_d;
  logic [2:0] edges;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      edges <= '0;
    end else begin
      sck_d <= sck;
      if (cs_n)              edges <= '0;
      else if (sck && !sck_d) edges <= edges + 3'd1;
    end
  end

  assert_sck_framed_R4: assert property (@(posedge clk) disable iff (rst)
    sck |-> !cs_n);

  assert_mosi_high_R4: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));

  assert_mosi_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi));

  assert_cs_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (edges == 3'd0 && !sck));

  assert_ready_framed_R9: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> !cs_n);

  assert_end_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
endmodule

bind pgwr_seq pgwr_seq_chk u_chk (
  .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
  .wr_ready(wr_ready), .done(done), .err(err)
);

// File: tb/sim_pgwr_seq.sv
`timescale 1ns/1ps
module sim_pgwr_seq;
  localparam int DIV = 2;
  localparam int PM  = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] addr_i = '0;
  logic [8:0]  len_i = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready, done, err, sck, cs_n, mosi, miso;
  logic [1:0]  err_code;

  always #5 clk = ~clk;

  pgwr_seq #(.DIV(DIV), .POLL_MAX(PM)) u0 (
    .clk(clk), .rst(rst), .start(start), .addr(addr_i), .len(len_i),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .done(done), .err(err), .err_code(err_code),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int tests = 0, fails = 0;

  // flash model state
  int   nfr, bitc, stat_seen, busy_polls, misalign, badhi, hic;
  bit   wel_stuck, in_frame, pend, sh_on;
  logic [7:0] sh, tx_sr;
  logic [7:0] fop [0:63];
  int   flen [0:63];
  logic [7:0] pbuf [0:299];
  logic [7:0] txd  [0:299];
  int   k, cur_len;
  bit   feed_en, hs_pend;

  assign miso = tx_sr[7];

  initial begin
    nfr = 0; bitc = 0; stat_seen = 0; busy_polls = 0; misalign = 0; badhi = 0; hic = 0;
    wel_stuck = 0; in_frame = 0; pend = 0; sh_on = 0; sh = '0; tx_sr = '0;
    k = 0; cur_len = 0; feed_en = 0; hs_pend = 0;
  end

  always @(negedge cs_n) begin
    in_frame = 1; bitc = 0; sh = '0; tx_sr = '0; pend = 0; sh_on = 0;
  end

  always @(posedge sck) if (in_frame) begin
    int bi;
    bit bz;
    sh = {sh[6:0], mosi};
    bitc++;
    if (bitc % 8 == 0) begin
      bi = bitc / 8 - 1;
      if (bi == 0 && nfr < 64) fop[nfr] = sh;
      if (nfr == 1 && bi < 300) pbuf[bi] = sh;
      if (bi == 0 && sh == 8'h05) begin
        bz = (stat_seen < busy_polls);
        stat_seen++;
        tx_sr = {6'b0, wel_stuck | bz, bz};
        pend = 1;
      end
    end
  end

  always @(negedge sck) if (in_frame) begin
    if (pend) begin pend = 0; sh_on = 1; end
    else if (sh_on) tx_sr = {tx_sr[6:0], 1'b0};
  end

  always @(posedge cs_n) if (in_frame) begin
    in_frame = 0;
    if (bitc % 8 != 0) misalign++;
    if (nfr < 64) flen[nfr] = bitc / 8;
    nfr++;
  end

  always @(negedge clk) if (!rst) begin
    if (sck) hic++;
    else begin
      if (hic != 0 && hic != DIV) badhi++;
      hic = 0;
    end
  end

  always @(negedge clk) begin
    if (hs_pend) begin k++; hs_pend = 0; end
    if (feed_en && k < cur_len) begin
      wr_valid = ($urandom % 4) != 0;
      wr_data  = txd[k];
      if (wr_valid && wr_ready) hs_pend = 1;
    end else begin
      wr_valid = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [23:0] a, input int n, input int bp, input bit ws);
    if (n == 0 || int'(a[7:0]) + n > 256) return 1;
    if (bp >= PM) return 2;
    if (ws) return 3;
    return 0;
  endfunction

  task automatic run(input logic [23:0] a, input int n, input int bp, input bit ws);
    int ec, got, w, nstat, dmis;
    ec = exp_code(a, n, bp, ws);
    for (int i = 0; i < 300; i++) txd[i] = 8'($urandom);
    nfr = 0; stat_seen = 0; misalign = 0; badhi = 0;
    busy_polls = bp; wel_stuck = ws;
    k = 0; hs_pend = 0; cur_len = (ec == 1) ? 0 : n; feed_en = 1;
    @(negedge clk);
    addr_i = a; len_i = 9'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!(done || err) && w < 40000) begin @(negedge clk); w++; end
    if (w >= 40000) begin
      chk(0, "watchdog R7", w, 0);
      return;
    end
    got = err ? int'(err_code) : 0;
    chk(!(done && err), "R7 done/err exclusive", done + err, 1);
    chk(got == ec, "R1/R7/R8 end code", got, ec);
    repeat (4 * DIV) @(negedge clk);
    feed_en = 0;
    chk(wr_ready == 1'b0, "R9 ready low after end", wr_ready, 0);
    if (ec == 1) begin
      chk(nfr == 0 && cs_n == 1'b1, "R1 no bus activity", nfr, 0);
      return;
    end
    chk(fop[0] == 8'h06 && flen[0] == 1, "R2 write-enable frame", flen[0], 1);
    chk(fop[1] == 8'h02 && flen[1] == 4 + n, "R3 program frame length", flen[1], 4 + n);
    chk({pbuf[1], pbuf[2], pbuf[3]} == a, "R3 address bytes",
        int'({pbuf[1], pbuf[2], pbuf[3]}), int'(a));
    dmis = 0;
    for (int i = 0; i < n; i++) if (pbuf[4 + i] !== txd[i]) dmis++;
    chk(dmis == 0, "R3 payload bytes", dmis, 0);
    chk(k == n, "R9 handshake count", k, n);
    nstat = (ec == 2) ? PM : bp + 1;
    chk(nfr == 2 + nstat, "R6/R8 status frame count", nfr - 2, nstat);
    dmis = 0;
    for (int i = 2; i < nfr && i < 64; i++) if (fop[i] != 8'h05 || flen[i] != 2) dmis++;
    chk(dmis == 0, "R6 status frame shape", dmis, 0);
    chk(misalign == 0, "R5 cs_n on byte boundary", misalign, 0);
    chk(badhi == 0, "R10 sck high time", badhi, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++; tests++;
    $display("FAIL watchdog expired R7 actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1 && sck == 0 && !done && !err && !wr_ready, "R11 reset state",
        {cs_n, sck, done, err, wr_ready}, 5'b10000);
    run(24'h123400, 0, 0, 0);      // R1 zero count
    run(24'h0AB0F0, 17, 0, 0);     // R1 one past page end
    run(24'h0AB0F0, 16, 0, 0);     // exactly to page end
    run(24'h3C0100, 256, 2, 0);    // full page, R3
    run(24'h7F12FF, 1, 0, 0);      // last byte of page
    run(24'h001020, 5, PM, 0);     // R8 timeout
    run(24'h001020, 5, PM - 1, 0); // last allowed poll
    run(24'h440000, 3, 1, 1);      // R7 write-enable stuck
    for (int t = 0; t < 8; t++) begin
      logic [23:0] a;
      int n, lim;
      a = 24'($urandom);
      if ($urandom % 4 == 0) begin
        n = (a[7:0] == 0) ? 0 : 257 - int'(a[7:0]) + int'($urandom % 8);
        if (n > 256) n = 256;
        if (a[7:0] == 1 && n < 256) n = 256;
      end else begin
        lim = 256 - int'(a[7:0]);
        if (lim > 64) lim = 64;
        n = 1 + int'($urandom % lim);
      end
      run(a, n, int'($urandom % 4), ($urandom % 5) == 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule